// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

This block is a serial port that sits as a peripheral on a shared processor command bus. A command is a 3-bit operation code with an 8-bit data value. The port takes no part in the bus until a select command carries its own device number. A select command with any other number releases it. While the port is selected it accepts two set commands that load its line program, a write command that hands it a byte to send, and a read command that returns the last received character.

All line parameters are loaded at run time: the character length (5 to 8 data bits), parity enable and parity sense, one or two stop bits, a 4-bit bit-rate code and half- or full-duplex operation. The receiver oversamples the line at 16 ticks per bit and samples each bit at its midpoint. Four flag lines with fixed meanings report the port's state: a character is waiting, the transmit holding register is free, the line is faulted, and the waiting character has a parity error. An interrupt request rises together with the "character waiting" flag.

Top module: `serial_port`

## Requirements
- R1: A select command (op 0) sets `sel_o` when its data equals `DEV_ID` and clears it otherwise. While `sel_o` is low, set, write and read commands have no effect.
- R2: Op 1 loads the format: data[1:0] is the character length minus 5, bit 2 enables parity, bit 3 selects odd parity (0 = even), bit 4 selects two stop bits. Op 2 loads the rate: data[3:0] is the rate code and bit 4 selects half duplex. After reset the port uses 8 data bits, no parity, one stop bit, code 0 and full duplex.
- R3: A transmitted frame is one low start bit, then the data bits LSB first, then the parity bit if enabled, then one or two high stop bits. The line is high when idle. Even parity makes the count of ones in the data and parity bits even.
- R4: Every bit lasts 16·BASE_DIV·(code+1) clock cycles.
- R5: `flag_o[1]` is high when the transmit holding register is empty. A selected write (op 3) clears it in the next cycle. It rises again once the transmitter has taken the byte.
- R6: The receiver samples each bit at its midpoint. A start bit that is no longer low at its midpoint is discarded and delivers nothing.
- R7: A received character sets `flag_o[0]` and `irq_o` together. A selected read (op 4) drives the character on `bus_data_o` in the same cycle, with the unused upper bits zero. The read clears `flag_o[0]`, `flag_o[3]` and `irq_o`.
- R8: `flag_o[3]` rises together with `flag_o[0]` when the received parity bit does not match the programmed parity.
- R9: A frame whose stop bit is low is discarded. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: `flag_o[2]` is set once the receive line has stayed low for 384 oversampling ticks (two 12-bit character times). It stays set after the line recovers, until a selected read is issued while the line is high.
- R11: In half-duplex mode the receiver does not begin a frame while the transmitter is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation: 0 select, 1 set format, 2 set rate, 3 write, 4 read |
| bus_data_i | input | 8 | Command data |
| bus_data_o | output | 8 | Received character during a selected read, otherwise 0 |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| sel_o | output | 1 | Port is selected |
| flag_o | output | 4 | [0] character waiting, [1] transmit free, [2] line fault, [3] parity error |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the port with BASE_DIV = 1 and DEV_ID = 8'h5A. With these values a bit lasts only 16 cycles at code 0 and 48 cycles at code 2. Frames in several formats therefore fit into a short run, and a rate change shows up directly when the bench samples bits at mid-bit. The same setting brings the 384-tick open-line threshold down to 384 cycles, so a stuck-low line can be held past it.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int OVS            = 16;
  localparam int MAX_FRAME_BITS = 12;
  localparam int OPEN_TICKS     = 2 * OVS * MAX_FRAME_BITS;

  typedef enum logic [2:0] {
    OP_SELECT   = 3'd0,
    OP_SET_FMT  = 3'd1,
    OP_SET_RATE = 3'd2,
    OP_WRITE    = 3'd3,
    OP_READ     = 3'd4
  } op_e;

  typedef struct packed {
    logic       half;
    logic [3:0] rate;
    logic       stop2;
    logic       par_odd;
    logic       par_en;
    logic [1:0] len;
  } cfg_t;

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction
endpackage

// File: rtl/serial_port_baud.sv
module serial_port_baud #(
  parameter int BASE_DIV = 27
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] rate_i,
  output logic       tick_o
);
  localparam int MAXDIV = BASE_DIV * 16;
  localparam int DW     = $clog2(MAXDIV + 1);

  logic [DW-1:0] cnt_q, lim;

  always_comb lim = DW'(BASE_DIV * (int'(rate_i) + 1) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_port_tx.sv
module serial_port_tx
  import serial_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  cfg_t       cfg_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic       tx_o,
  output logic       thr_empty_o,
  output logic       busy_o
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;

  tst_e       st_q;
  logic [3:0] tcnt_q;
  logic [2:0] idx_q;
  logic       sidx_q, par_q;
  logic [7:0] sh_q, thr_q;
  logic [7:0] thr_m;

  assign thr_m = thr_q & len_mask(cfg_i.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= T_IDLE;
      tcnt_q      <= '0;
      idx_q       <= '0;
      sidx_q      <= 1'b0;
      par_q       <= 1'b0;
      sh_q        <= '0;
      thr_q       <= '0;
      thr_empty_o <= 1'b1;
    end else begin
      if (wr_i) begin
        thr_q       <= wr_data_i;
        thr_empty_o <= 1'b0;
      end
      if (st_q == T_IDLE) begin
        if (!thr_empty_o) begin
          st_q   <= T_START;
          tcnt_q <= '0;
          sh_q   <= thr_m;
          par_q  <= (^thr_m) ^ cfg_i.par_odd;
          if (!wr_i) thr_empty_o <= 1'b1;
        end
      end else if (tick_i) begin
        tcnt_q <= tcnt_q + 1'b1;
        if (tcnt_q == 4'd15) begin
          unique case (st_q)
            T_START: begin
              st_q  <= T_DATA;
              idx_q <= '0;
            end
            T_DATA: begin
              if (idx_q == 3'(cfg_i.len) + 3'd4) begin
                st_q   <= cfg_i.par_en ? T_PAR : T_STOP;
                sidx_q <= 1'b0;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            T_PAR: begin
              st_q   <= T_STOP;
              sidx_q <= 1'b0;
            end
            T_STOP: begin
              if (cfg_i.stop2 && !sidx_q) sidx_q <= 1'b1;
              else                        st_q   <= T_IDLE;
            end
            default: st_q <= T_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (st_q)
      T_START: tx_o = 1'b0;
      T_DATA:  tx_o = sh_q[idx_q];
      T_PAR:   tx_o = par_q;
      default: tx_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != T_IDLE);
endmodule

// File: rtl/serial_port_rx.sv
module serial_port_rx
  import serial_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  cfg_t       cfg_i,
  input  logic       rx_i,
  input  logic       block_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       fault_o,
  output logic       line_o
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT} rst_e;
  localparam int OW = $clog2(OPEN_TICKS + 1);

  rst_e          st_q;
  logic [1:0]    sync_q;
  logic          rxs, pbit_q;
  logic [3:0]    tcnt_q;
  logic [2:0]    idx_q;
  logic [OW-1:0] open_q;

  assign rxs    = sync_q[1];
  assign line_o = rxs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      open_q <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      if (rxs)                                            open_q <= '0;
      else if (tick_i && open_q != OW'(OPEN_TICKS))       open_q <= open_q + 1'b1;
    end
  end

  assign fault_o = (open_q == OW'(OPEN_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= R_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      pbit_q <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        R_IDLE: if (!rxs && !block_i) begin
          st_q   <= R_START;
          tcnt_q <= '0;
          data_o <= '0;
        end
        R_START: if (tick_i) begin
          if (tcnt_q == 4'd7) begin
            st_q   <= rxs ? R_IDLE : R_DATA;
            tcnt_q <= '0;
            idx_q  <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        R_DATA: if (tick_i) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (tcnt_q == 4'd15) begin
            data_o[idx_q] <= rxs;
            if (idx_q == 3'(cfg_i.len) + 3'd4) st_q <= cfg_i.par_en ? R_PAR : R_STOP;
            else                               idx_q <= idx_q + 1'b1;
          end
        end
        R_PAR: if (tick_i) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (tcnt_q == 4'd15) begin
            pbit_q <= rxs;
            st_q   <= R_STOP;
          end
        end
        R_STOP: if (tick_i) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (tcnt_q == 4'd15) begin
            if (rxs) begin
              done_o <= 1'b1;
              perr_o <= cfg_i.par_en && (pbit_q != ((^data_o) ^ cfg_i.par_odd));
              st_q   <= R_IDLE;
            end else st_q <= R_WAIT;
          end
        end
        R_WAIT: if (rxs) st_q <= R_IDLE;
        default: st_q <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_port.sv
module serial_port
  import serial_port_pkg::*;
#(
  parameter int         BASE_DIV = 27,
  parameter logic [7:0] DEV_ID   = 8'h08
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_op_i,
  input  logic [7:0] bus_data_i,
  output logic [7:0] bus_data_o,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       sel_o,
  output logic [3:0] flag_o,
  output logic       irq_o
);
  cfg_t       cfg_q;
  logic       tick, hit, rd, wr;
  logic       rx_done, rx_perr, rx_fault, rx_line, tx_busy, thr_empty;
  logic [7:0] rx_data, rx_buf_q;
  logic       full_q, perr_q, fault_q;
  op_e        op;

  assign op  = op_e'(cmd_op_i);
  assign hit = cmd_valid_i && sel_o;
  assign rd  = hit && (op == OP_READ);
  assign wr  = hit && (op == OP_WRITE);

  serial_port_baud #(.BASE_DIV(BASE_DIV)) u_baud (
    .clk_i, .rst_ni, .rate_i(cfg_q.rate), .tick_o(tick)
  );

  serial_port_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg_q), .wr_i(wr), .wr_data_i(bus_data_i),
    .tx_o, .thr_empty_o(thr_empty), .busy_o(tx_busy)
  );

  serial_port_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg_q), .rx_i,
    .block_i(cfg_q.half && tx_busy), .done_o(rx_done), .data_o(rx_data),
    .perr_o(rx_perr), .fault_o(rx_fault), .line_o(rx_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= 1'b0;
      cfg_q    <= '{half: 1'b0, rate: 4'd0, stop2: 1'b0, par_odd: 1'b0, par_en: 1'b0, len: 2'd3};
      full_q   <= 1'b0;
      perr_q   <= 1'b0;
      fault_q  <= 1'b0;
      rx_buf_q <= '0;
    end else begin
      if (cmd_valid_i && op == OP_SELECT) sel_o <= (bus_data_i == DEV_ID);
      if (hit && op == OP_SET_FMT) begin
        cfg_q.len     <= bus_data_i[1:0];
        cfg_q.par_en  <= bus_data_i[2];
        cfg_q.par_odd <= bus_data_i[3];
        cfg_q.stop2   <= bus_data_i[4];
      end
      if (hit && op == OP_SET_RATE) begin
        cfg_q.rate <= bus_data_i[3:0];
        cfg_q.half <= bus_data_i[4];
      end
      if (rx_done) begin
        full_q   <= 1'b1;
        perr_q   <= rx_perr;
        rx_buf_q <= rx_data;
      end else if (rd) begin
        full_q <= 1'b0;
        perr_q <= 1'b0;
      end
      if (rx_fault)          fault_q <= 1'b1;
      else if (rd && rx_line) fault_q <= 1'b0;
    end
  end

  assign bus_data_o = rd ? rx_buf_q : 8'h00;
  assign flag_o     = {perr_q, fault_q, thr_empty, full_q};
  assign irq_o      = full_q;
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk #(
  parameter logic [7:0] DEV_ID = 8'h08
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_op_i,
  input logic [7:0] bus_data_i,
  input logic       sel_o,
  input logic [3:0] flag_o,
  input logic       irq_o,
  input logic       rx_done
);
  p_select_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd0 && bus_data_i == DEV_ID) |=> sel_o);

  p_deselect_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd0 && bus_data_i != DEV_ID) |=> !sel_o);

  p_unsel_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_o && cmd_valid_i && cmd_op_i == 3'd3 && flag_o[1]) |=> flag_o[1]);

  p_write_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && cmd_valid_i && cmd_op_i == 3'd3) |=> !flag_o[1]);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && cmd_valid_i && cmd_op_i == 3'd4 && !rx_done) |=> (!flag_o[0] && !flag_o[3] && !irq_o));

  p_perr_with_char_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o[3] |-> flag_o[0]);
endmodule

bind serial_port serial_port_chk #(.DEV_ID(DEV_ID)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .bus_data_i(bus_data_i), .sel_o(sel_o), .flag_o(flag_o), .irq_o(irq_o), .rx_done(rx_done)
);

// File: tb/tb_serial_port.sv
module tb_serial_port;
  localparam logic [7:0] ID = 8'h5A;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       rx = 1'b1;
  logic       tx, sel, irq;
  logic [3:0] flag;

  int tests = 0, fails = 0, inv_fails = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_port #(.BASE_DIV(1), .DEV_ID(ID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .bus_data_i(din), .bus_data_o(dout), .rx_i(rx), .tx_o(tx), .sel_o(sel),
    .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock reference relations: irq follows the character flag, parity error only with a character
  always @(negedge clk) if (rst_n && !done) begin
    if (irq !== flag[0]) inv_fails++;
    if (flag[3] && !flag[0]) inv_fails++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; din = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_cmd(output logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; din = 8'h00;
    #2 d = dout;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic send_rx(input logic [7:0] d, input int n, input bit pen, input bit odd,
                         input bit badpar, input bit badstop, input int p);
    rx = 1'b0; repeat (p) @(negedge clk);
    for (int i = 0; i < n; i++) begin rx = d[i]; repeat (p) @(negedge clk); end
    if (pen) begin
      rx = par_of(d & (8'hFF >> (8 - n)), odd) ^ badpar; repeat (p) @(negedge clk);
    end
    rx = !badstop; repeat (p) @(negedge clk);
    rx = 1'b1;
  endtask

  // decodes one transmitted frame at mid-bit points
  task automatic rx_tx(input int n, input bit pen, input int nstop, input int p,
                       output logic [7:0] d, output logic pb, output bit ok);
    int w = 0;
    d = 8'h00; pb = 1'b0; ok = 1'b1;
    while (tx !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    if (w >= 4000) begin ok = 1'b0; return; end
    repeat (p / 2) @(negedge clk);
    if (tx !== 1'b0) ok = 1'b0;
    for (int i = 0; i < n; i++) begin repeat (p) @(negedge clk); d[i] = tx; end
    if (pen) begin repeat (p) @(negedge clk); pb = tx; end
    for (int s = 0; s < nstop; s++) begin repeat (p) @(negedge clk); if (tx !== 1'b1) ok = 1'b0; end
  endtask

  initial begin
    logic [7:0] d;
    logic pb;
    bit ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset flags", flag, 4'b0010);
    chk("R1 reset unselected", sel, 0);
    chk("R3 idle line high", tx, 1);

    // R1: unselected write has no effect
    cmd(3'd3, 8'hA5);
    repeat (40) @(negedge clk);
    chk("R1 unselected write flag2", flag[1], 1);
    chk("R1 unselected write line", tx, 1);

    cmd(3'd0, 8'h11);
    chk("R1 other id", sel, 0);
    cmd(3'd0, ID);
    chk("R1 own id", sel, 1);

    // R3/R4/R5: default 8N1, code 0
    cmd(3'd3, 8'hA5);
    chk("R5 write clears flag2", flag[1], 0);
    rx_tx(8, 0, 1, 16, d, pb, ok);
    chk("R3 8N1 data", d, 8'hA5);
    chk("R4 8N1 framing", ok, 1);
    chk("R5 flag2 back", flag[1], 1);

    // R2/R3/R4: 7 bits even parity two stops, code 2 -> 48 cycles
    cmd(3'd1, 8'h16);
    cmd(3'd2, 8'h02);
    cmd(3'd3, 8'hC3);
    rx_tx(7, 1, 2, 48, d, pb, ok);
    chk("R2 7-bit data", d, 8'h43);
    chk("R3 even parity bit", pb, 1);
    chk("R4 code2 framing", ok, 1);

    cmd(3'd1, 8'h03);
    cmd(3'd2, 8'h00);

    // R1: set while unselected is ignored
    cmd(3'd0, 8'h00);
    cmd(3'd2, 8'h05);
    cmd(3'd0, ID);
    cmd(3'd3, 8'h3C);
    rx_tx(8, 0, 1, 16, d, pb, ok);
    chk("R1 unselected set ignored", d, 8'h3C);
    chk("R1 unselected set framing", ok, 1);

    // R7: receive and read
    send_rx(8'h96, 8, 0, 0, 0, 0, 16);
    repeat (20) @(negedge clk);
    chk("R7 char flag", flag[0], 1);
    chk("R7 irq", irq, 1);
    chk("R8 no parity error", flag[3], 0);
    // R1: unselected read leaves the character pending
    cmd(3'd0, 8'h22);
    rd_cmd(d);
    chk("R1 unselected read bus", d, 8'h00);
    chk("R1 unselected read flag", flag[0], 1);
    cmd(3'd0, ID);
    rd_cmd(d);
    chk("R7 read data", d, 8'h96);
    chk("R7 read clears", {irq, flag[3], flag[0]}, 3'b000);

    // R8: odd parity 8 bits
    cmd(3'd1, 8'h0F);
    send_rx(8'h81, 8, 1, 1, 0, 0, 16);
    repeat (20) @(negedge clk);
    chk("R8 good odd parity", flag[3], 0);
    rd_cmd(d);
    chk("R8 good parity data", d, 8'h81);
    send_rx(8'h81, 8, 1, 1, 1, 0, 16);
    repeat (20) @(negedge clk);
    chk("R8 bad parity flags", {flag[3], flag[0]}, 2'b11);
    rd_cmd(d);
    chk("R8 read clears parity", {flag[3], flag[0]}, 2'b00);

    // R7: 5-bit character, upper bits zero
    cmd(3'd1, 8'h00);
    send_rx(8'hF5, 5, 0, 0, 0, 0, 16);
    repeat (20) @(negedge clk);
    rd_cmd(d);
    chk("R7 5-bit data", d, 8'h15);
    cmd(3'd1, 8'h03);

    // R6: short low pulse rejected
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (300) @(negedge clk);
    chk("R6 glitch rejected", flag[0], 0);

    // R9: low stop bit discards frame
    send_rx(8'h5B, 8, 0, 0, 0, 1, 16);
    repeat (300) @(negedge clk);
    chk("R9 bad stop discarded", flag[0], 0);

    // R10: open line
    rx = 1'b0; repeat (450) @(negedge clk);
    chk("R10 fault set", flag[2], 1);
    rx = 1'b1; repeat (20) @(negedge clk);
    chk("R10 fault latched", flag[2], 1);
    chk("R10 no char", flag[0], 0);
    rd_cmd(d);
    chk("R10 read clears fault", flag[2], 0);

    // R11: half duplex blocks receive while sending
    cmd(3'd2, 8'h10);
    cmd(3'd3, 8'hFF);
    fork
      rx_tx(8, 0, 1, 16, d, pb, ok);
      send_rx(8'h42, 8, 0, 0, 0, 0, 16);
    join
    repeat (40) @(negedge clk);
    chk("R11 half duplex blocked", flag[0], 0);
    cmd(3'd2, 8'h00);
    cmd(3'd3, 8'hFF);
    fork
      rx_tx(8, 0, 1, 16, d, pb, ok);
      send_rx(8'h42, 8, 0, 0, 0, 0, 16);
    join
    repeat (40) @(negedge clk);
    chk("R11 full duplex receives", flag[0], 1);
    rd_cmd(d);
    chk("R11 full duplex data", d, 8'h42);

    chk("R7 R8 per-clock irq and flag relations", inv_fails, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule